// File: doc/BRIEF.md
# Abstract Register Access Sequencer

This block carries out the register-access abstract command of a debug unit. A debugger writes a 32-bit command word. The block checks the command type and reads the write flag and a 16-bit register number. It then moves one word between a shared data register and one of three kinds of core register: control/status registers (CSRs), the scalar register file or the floating-point register file. Each kind of register uses its own handshake. A CSR access is a one-cycle command strobe, and a CSR read returns its data later through a valid-only pulse. A scalar register write is a valid/ready transfer. A floating-point register write is a single valid strobe. Reads from either register file use a combinational index/data port.

While an access runs, the block raises a busy flag. When a command cannot be executed, it stores a 3-bit error code instead of running it. The error code stays until the debugger clears it, and the block ignores commands while the code is nonzero. The debugger loads the data register before a write command and reads it after a read command. The data register accepts debugger writes only while no access is running.

Top module: `abs_reg_seq`

## Requirements
- R1: A command whose bits 31:24 are not zero sets cmderr to 2 and starts no access: busy stays 0, no destination strobe is raised, and data0 keeps its value. The type check comes before the range check.
- R2: A type-0 command whose register number (bits 15:0) is above 0x103F sets cmderr to 3 and starts no access.
- R3: A register number from 0x0000 to 0x0FFF raises csr_valid for exactly one cycle. In that cycle csr_addr carries regno[11:0], csr_write carries command bit 16, and csr_wdata carries data0. A CSR write ends in that same cycle.
- R4: A CSR read waits in busy until csr_rd_valid is seen, then loads csr_rd_data into data0 and ends.
- R5: A register number from 0x1000 to 0x101F selects scalar index regno-0x1000 (0x100A is index 10). A read loads sc_rd_data into data0 after one busy cycle.
- R6: A scalar write raises sc_wr_valid with sc_wr_idx and sc_wr_data = data0 and holds all three unchanged until a cycle in which sc_wr_ready is 1. The access ends in that cycle.
- R7: A register number from 0x1020 to 0x103F selects floating-point index regno-0x1020. A read loads fp_rd_data into data0. A write raises fp_wr_valid for exactly one cycle with data0 as its data.
- R8: busy is 1 from the cycle after a command is accepted until the access ends, and busy is 0 at all other times. cmderr remains 0 after a successful access.
- R9: A command write while busy is 1 sets cmderr to 1, and the running access continues unchanged. This includes a write in the last cycle of the access.
- R10: A nonzero cmderr keeps its value until err_clr is pulsed, and commands written while it is nonzero are ignored. If an error is set in the same cycle as err_clr, the error wins.
- R11: A debugger write to data0 takes effect when busy is 0 and is ignored when busy is 1.
- R12: After reset, busy is 0, cmderr is 0, data0 is 0 and no strobe is raised. At most one of csr_valid, sc_wr_valid and fp_wr_valid is ever 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: type 31:24, write flag 16, register number 15:0 |
| data0_we | input | 1 | Data register write strobe from the debugger |
| data0_wdata | input | 32 | Value for the data register |
| err_clr | input | 1 | Clears cmderr |
| data0 | output | 32 | Data register contents |
| busy | output | 1 | An access is running |
| cmderr | output | 3 | Error code: 0 none, 1 busy, 2 unsupported, 3 exception |
| csr_valid | output | 1 | CSR command strobe |
| csr_write | output | 1 | CSR command is a write |
| csr_addr | output | 12 | CSR address |
| csr_wdata | output | 32 | CSR write data |
| csr_rd_valid | input | 1 | CSR read data is valid |
| csr_rd_data | input | 32 | CSR read data |
| sc_wr_valid | output | 1 | Scalar register write request |
| sc_wr_ready | input | 1 | Scalar register file accepts the write |
| sc_wr_idx | output | 5 | Scalar write index |
| sc_wr_data | output | 32 | Scalar write data |
| sc_rd_idx | output | 5 | Scalar read index |
| sc_rd_data | input | 32 | Scalar read data (combinational) |
| fp_wr_valid | output | 1 | Floating-point register write strobe |
| fp_wr_idx | output | 5 | Floating-point write index |
| fp_wr_data | output | 32 | Floating-point write data |
| fp_rd_idx | output | 5 | Floating-point read index |
| fp_rd_data | input | 32 | Floating-point read data (combinational) |

## Verification
A new command write can arrive in the same cycle in which a running access finishes. This is the last cycle in which busy is still 1. The bench provokes it by holding cmd_we high for the cycle after a scalar read is accepted, so the second write meets the completing read. The result is judged correct only if cmderr becomes 1, data0 still receives the value of the first register, and busy drops. A second overlap, an error being set in the same cycle as err_clr, is checked by expecting the new error code to survive.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;
   localparam int CMD_W    = 32;
   localparam int TYPE_LSB = 24;
   localparam int WR_BIT   = 16;
   localparam int REGNO_W  = 16;
   localparam int ERR_W    = 3;

   localparam logic [ERR_W-1:0] ERR_NONE  = 3'd0;
   localparam logic [ERR_W-1:0] ERR_BUSY  = 3'd1;
   localparam logic [ERR_W-1:0] ERR_UNSUP = 3'd2;
   localparam logic [ERR_W-1:0] ERR_EXC   = 3'd3;

   typedef enum logic [1:0] {DEST_CSR, DEST_SC, DEST_FP, DEST_BAD} dest_e;
   typedef enum logic [1:0] {LOAD_NONE, LOAD_CSR, LOAD_SC, LOAD_FP} load_e;
   typedef enum logic [2:0] {
      S_IDLE, S_CSR_ISSUE, S_CSR_WAIT, S_SC_RD, S_SC_WR, S_FP_RD, S_FP_WR
   } seq_state_e;
endpackage

// File: rtl/abs_seq_decode.sv
module abs_seq_decode
   import abs_seq_pkg::*;
#(
   parameter int CSR_SPAN  = 4096,
   parameter int SC_BASE   = 4096,
   parameter int FP_BASE   = 4128,
   parameter int RF_DEPTH  = 32,
   parameter bit HAS_FLOAT = 1'b1,
   localparam int IW      = $clog2(RF_DEPTH),
   localparam int CSR_AW  = $clog2(CSR_SPAN)
) (
   input  logic [CMD_W-1:0]  cmd,
   output logic              type_ok,
   output logic              is_write,
   output dest_e             dest,
   output logic [IW-1:0]     idx,
   output logic [CSR_AW-1:0] csr_addr
);
   localparam logic [REGNO_W-1:0] CSR_END = REGNO_W'(CSR_SPAN);
   localparam logic [REGNO_W-1:0] SC_LO   = REGNO_W'(SC_BASE);
   localparam logic [REGNO_W-1:0] SC_HI   = REGNO_W'(SC_BASE + RF_DEPTH);
   localparam logic [REGNO_W-1:0] FP_LO   = REGNO_W'(FP_BASE);
   localparam logic [REGNO_W-1:0] FP_HI   = REGNO_W'(FP_BASE + RF_DEPTH);

   logic [REGNO_W-1:0] regno, sc_off, fp_off;
   logic               csr_hit, sc_hit, fp_hit;

   assign type_ok  = (cmd[CMD_W-1:TYPE_LSB] == '0);
   assign is_write = cmd[WR_BIT];
   assign regno    = cmd[REGNO_W-1:0];
   assign sc_off   = regno - SC_LO;
   assign fp_off   = regno - FP_LO;
   assign csr_hit  = (regno < CSR_END);
   assign sc_hit   = (regno >= SC_LO) && (regno < SC_HI);

   generate
      if (HAS_FLOAT) begin : g_fp_on
         assign fp_hit = (regno >= FP_LO) && (regno < FP_HI);
      end else begin : g_fp_off
         assign fp_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (csr_hit)     dest = DEST_CSR;
      else if (sc_hit) dest = DEST_SC;
      else if (fp_hit) dest = DEST_FP;
      else             dest = DEST_BAD;
   end

   assign idx      = fp_hit ? fp_off[IW-1:0] : sc_off[IW-1:0];
   assign csr_addr = regno[CSR_AW-1:0];

   logic unused_fields;
   assign unused_fields = ^{cmd[TYPE_LSB-1:WR_BIT+1], sc_off[REGNO_W-1:IW], fp_off[REGNO_W-1:IW],
                            regno[REGNO_W-1:CSR_AW]};
endmodule

// File: rtl/abs_seq_fsm.sv
module abs_seq_fsm
   import abs_seq_pkg::*;
#(
   parameter int IW     = 5,
   parameter int CSR_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  dest_e             dest,
   input  logic              is_write,
   input  logic [IW-1:0]     idx,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic              csr_rd_valid,
   input  logic              sc_wr_ready,
   output logic              busy,
   output logic              csr_valid,
   output logic              csr_write,
   output logic [CSR_AW-1:0] csr_addr_q,
   output logic              sc_wr_valid,
   output logic              fp_wr_valid,
   output logic [IW-1:0]     idx_q,
   output load_e             load_sel
);
   seq_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      load_sel = LOAD_NONE;
      unique case (state)
         S_IDLE: if (start) begin
            unique case (dest)
               DEST_CSR: state_nx = S_CSR_ISSUE;
               DEST_SC:  state_nx = is_write ? S_SC_WR : S_SC_RD;
               DEST_FP:  state_nx = is_write ? S_FP_WR : S_FP_RD;
               default:  state_nx = S_IDLE;
            endcase
         end
         S_CSR_ISSUE: begin
            if (csr_write) state_nx = S_IDLE;
            else if (csr_rd_valid) begin
               state_nx = S_IDLE;
               load_sel = LOAD_CSR;
            end else state_nx = S_CSR_WAIT;
         end
         S_CSR_WAIT: if (csr_rd_valid) begin
            state_nx = S_IDLE;
            load_sel = LOAD_CSR;
         end
         S_SC_RD: begin
            state_nx = S_IDLE;
            load_sel = LOAD_SC;
         end
         S_SC_WR: if (sc_wr_ready) state_nx = S_IDLE;
         S_FP_RD: begin
            state_nx = S_IDLE;
            load_sel = LOAD_FP;
         end
         S_FP_WR: state_nx = S_IDLE;
         default: state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         csr_write  <= 1'b0;
         csr_addr_q <= '0;
         idx_q      <= '0;
      end else begin
         state <= state_nx;
         if (state == S_IDLE && start) begin
            csr_write  <= is_write;
            csr_addr_q <= csr_addr;
            idx_q      <= idx;
         end
      end
   end

   assign busy        = (state != S_IDLE);
   assign csr_valid   = (state == S_CSR_ISSUE);
   assign sc_wr_valid = (state == S_SC_WR);
   assign fp_wr_valid = (state == S_FP_WR);
endmodule

// File: rtl/abs_seq_err.sv
module abs_seq_err
   import abs_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic [ERR_W-1:0] set_code,
   input  logic             clr,
   output logic [ERR_W-1:0] cmderr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cmderr <= ERR_NONE;
      else if (set) cmderr <= set_code;
      else if (clr) cmderr <= ERR_NONE;
   end
endmodule

// File: rtl/abs_reg_seq.sv
module abs_reg_seq
   import abs_seq_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CSR_SPAN  = 4096,
   parameter int SC_BASE   = 4096,
   parameter int FP_BASE   = 4128,
   parameter int RF_DEPTH  = 32,
   parameter bit HAS_FLOAT = 1'b1,
   localparam int IW      = $clog2(RF_DEPTH),
   localparam int CSR_AW  = $clog2(CSR_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              data0_we,
   input  logic [XLEN-1:0]   data0_wdata,
   input  logic              err_clr,
   output logic [XLEN-1:0]   data0,
   output logic              busy,
   output logic [ERR_W-1:0]  cmderr,
   output logic              csr_valid,
   output logic              csr_write,
   output logic [CSR_AW-1:0] csr_addr,
   output logic [XLEN-1:0]   csr_wdata,
   input  logic              csr_rd_valid,
   input  logic [XLEN-1:0]   csr_rd_data,
   output logic              sc_wr_valid,
   input  logic              sc_wr_ready,
   output logic [IW-1:0]     sc_wr_idx,
   output logic [XLEN-1:0]   sc_wr_data,
   output logic [IW-1:0]     sc_rd_idx,
   input  logic [XLEN-1:0]   sc_rd_data,
   output logic              fp_wr_valid,
   output logic [IW-1:0]     fp_wr_idx,
   output logic [XLEN-1:0]   fp_wr_data,
   output logic [IW-1:0]     fp_rd_idx,
   input  logic [XLEN-1:0]   fp_rd_data
);
   generate
      if (XLEN < 8)
         $error("abs_reg_seq: XLEN too small");
      if ((1 << IW) != RF_DEPTH)
         $error("abs_reg_seq: RF_DEPTH must be a power of two");
      if (SC_BASE < CSR_SPAN || (HAS_FLOAT && FP_BASE < SC_BASE + RF_DEPTH))
         $error("abs_reg_seq: register number ranges overlap");
      if ((HAS_FLOAT ? FP_BASE : SC_BASE) + RF_DEPTH > (1 << REGNO_W))
         $error("abs_reg_seq: register ranges exceed register number width");
   endgenerate

   logic              type_ok, is_write, accept, start, err_set;
   dest_e             dest;
   logic [IW-1:0]     dec_idx, idx_q;
   logic [CSR_AW-1:0] dec_csr;
   logic [ERR_W-1:0]  err_code;
   load_e             load_sel;

   abs_seq_decode #(
      .CSR_SPAN(CSR_SPAN), .SC_BASE(SC_BASE), .FP_BASE(FP_BASE),
      .RF_DEPTH(RF_DEPTH), .HAS_FLOAT(HAS_FLOAT)
   ) i_decode (
      .cmd(cmd_wdata), .type_ok(type_ok), .is_write(is_write), .dest(dest),
      .idx(dec_idx), .csr_addr(dec_csr)
   );

   assign accept = cmd_we && !busy && (cmderr == ERR_NONE);
   assign start  = accept && type_ok && (dest != DEST_BAD);

   always_comb begin
      err_set  = 1'b1;
      err_code = ERR_NONE;
      if (cmd_we && busy && cmderr == ERR_NONE) err_code = ERR_BUSY;
      else if (accept && !type_ok)              err_code = ERR_UNSUP;
      else if (accept && dest == DEST_BAD)      err_code = ERR_EXC;
      else                                      err_set  = 1'b0;
   end

   abs_seq_err i_err (
      .clk(clk), .rst_n(rst_n), .set(err_set), .set_code(err_code),
      .clr(err_clr), .cmderr(cmderr)
   );

   abs_seq_fsm #(.IW(IW), .CSR_AW(CSR_AW)) i_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .dest(dest), .is_write(is_write),
      .idx(dec_idx), .csr_addr(dec_csr), .csr_rd_valid(csr_rd_valid),
      .sc_wr_ready(sc_wr_ready), .busy(busy), .csr_valid(csr_valid),
      .csr_write(csr_write), .csr_addr_q(csr_addr), .sc_wr_valid(sc_wr_valid),
      .fp_wr_valid(fp_wr_valid), .idx_q(idx_q), .load_sel(load_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data0 <= '0;
      else begin
         unique case (load_sel)
            LOAD_CSR: data0 <= csr_rd_data;
            LOAD_SC:  data0 <= sc_rd_data;
            LOAD_FP:  data0 <= fp_rd_data;
            default:  if (data0_we && !busy) data0 <= data0_wdata;
         endcase
      end
   end

   assign csr_wdata  = data0;
   assign sc_wr_idx  = idx_q;
   assign sc_wr_data = data0;
   assign sc_rd_idx  = idx_q;
   assign fp_wr_idx  = idx_q;
   assign fp_wr_data = data0;
   assign fp_rd_idx  = idx_q;
endmodule

// File: rtl/abs_seq_chk.sv
module abs_seq_chk #(
   parameter int XLEN = 32,
   parameter int IW   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_we,
   input logic            err_clr,
   input logic            busy,
   input logic [2:0]      cmderr,
   input logic            csr_valid,
   input logic            sc_wr_valid,
   input logic            sc_wr_ready,
   input logic [IW-1:0]   sc_wr_idx,
   input logic [XLEN-1:0] sc_wr_data,
   input logic            fp_wr_valid
);
   assert_csr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      csr_valid |=> !csr_valid);

   assert_sc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sc_wr_valid && !sc_wr_ready |=> sc_wr_valid && $stable(sc_wr_idx) && $stable(sc_wr_data));

   assert_fp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fp_wr_valid |=> !fp_wr_valid);

   assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid || sc_wr_valid || fp_wr_valid) |-> busy);

   assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_we && cmderr == 3'd0 |=> cmderr == 3'd1);

   assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmderr != 3'd0 && !err_clr |=> $stable(cmderr));

   assert_err_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && cmderr != 3'd0 |=> !busy);

   assert_one_dest_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({csr_valid, sc_wr_valid, fp_wr_valid}));
endmodule

bind abs_reg_seq abs_seq_chk #(.XLEN(XLEN), .IW(IW)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .err_clr(err_clr), .busy(busy),
   .cmderr(cmderr), .csr_valid(csr_valid), .sc_wr_valid(sc_wr_valid),
   .sc_wr_ready(sc_wr_ready), .sc_wr_idx(sc_wr_idx), .sc_wr_data(sc_wr_data),
   .fp_wr_valid(fp_wr_valid)
);

// File: tb/test_abs_reg_seq.sv
`timescale 1ns/1ps
module test_abs_reg_seq;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cmd_we = 1'b0, data0_we = 1'b0, err_clr = 1'b0;
   logic [31:0] cmd_wdata = '0, data0_wdata = '0;
   logic [31:0] data0, csr_wdata, sc_wr_data, fp_wr_data, sc_rd_data, fp_rd_data;
   logic [31:0] csr_rd_data = '0;
   logic        busy, csr_valid, csr_write, sc_wr_valid, fp_wr_valid;
   logic        csr_rd_valid = 1'b0, sc_wr_ready = 1'b0;
   logic [2:0]  cmderr;
   logic [11:0] csr_addr;
   logic [4:0]  sc_wr_idx, sc_rd_idx, fp_wr_idx, fp_rd_idx;

   always #2.5 clk = ~clk;

   abs_reg_seq i_abs_reg_seq (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .data0_we(data0_we), .data0_wdata(data0_wdata), .err_clr(err_clr),
      .data0(data0), .busy(busy), .cmderr(cmderr), .csr_valid(csr_valid),
      .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rd_valid(csr_rd_valid), .csr_rd_data(csr_rd_data),
      .sc_wr_valid(sc_wr_valid), .sc_wr_ready(sc_wr_ready), .sc_wr_idx(sc_wr_idx),
      .sc_wr_data(sc_wr_data), .sc_rd_idx(sc_rd_idx), .sc_rd_data(sc_rd_data),
      .fp_wr_valid(fp_wr_valid), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data),
      .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data)
   );

   // bench-side register models
   logic [31:0] sc_mem [32];
   logic [31:0] fp_mem [32];
   logic [31:0] csr_mem [16];
   logic [11:0] last_csr_addr = '0;
   int          n_csr = 0, n_scw = 0, n_fpw = 0;
   int          rsp_wait = -1, csr_lat = 1;
   logic [3:0]  rsp_addr = '0;
   int          ready_mode = 0;  // 0 random, 1 low, 2 high
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;

   assign sc_rd_data = sc_mem[sc_rd_idx];
   assign fp_rd_data = fp_mem[fp_rd_idx];

   function automatic logic [31:0] seed_val(int kind, int i);
      return (32'h9E37_79B9 * (kind * 64 + i + 1)) ^ 32'h0F0F_1234;
   endfunction

   function automatic logic [31:0] mk_cmd(logic [7:0] ty, logic wr, logic [15:0] regno);
      return {ty, 7'd0, wr, regno};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) begin
            sc_mem[i] <= seed_val(1, i);
            fp_mem[i] <= seed_val(2, i);
         end
         for (int i = 0; i < 16; i++) csr_mem[i] <= seed_val(3, i);
      end else begin
         csr_rd_valid <= 1'b0;
         if (rsp_wait == 0) begin
            csr_rd_valid <= 1'b1;
            csr_rd_data  <= csr_mem[rsp_addr];
            rsp_wait     <= -1;
         end else if (rsp_wait > 0) rsp_wait <= rsp_wait - 1;
         if (csr_valid) begin
            n_csr++;
            last_csr_addr <= csr_addr;
            if (csr_write) csr_mem[csr_addr[3:0]] <= csr_wdata;
            else begin
               rsp_wait <= csr_lat;
               rsp_addr <= csr_addr[3:0];
            end
         end
         if (sc_wr_valid && sc_wr_ready) begin
            n_scw++;
            sc_mem[sc_wr_idx] <= sc_wr_data;
         end
         if (fp_wr_valid) begin
            n_fpw++;
            fp_mem[fp_wr_idx] <= fp_wr_data;
         end
      end
   end

   always @(negedge clk)
      sc_wr_ready <= (ready_mode == 2) || (ready_mode == 0 && $urandom_range(0, 2) == 0);

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr_data0(logic [31:0] v);
      @(negedge clk); data0_we = 1'b1; data0_wdata = v;
      @(negedge clk); data0_we = 1'b0;
   endtask

   task automatic send_cmd(logic [31:0] c);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 200) begin @(negedge clk); t++; end
      if (t >= 200) check("R8", "busy timeout", 32'(busy), 32'd0);
   endtask

   task automatic run_access(int cls, int idx, logic wr, logic [31:0] v);
      logic [15:0] rn;
      logic [31:0] exp;
      rn = (cls == 0) ? 16'(($urandom & 32'hFF0) | 32'(idx)) :
           (cls == 1) ? 16'(16'h1000 + idx) : 16'(16'h1020 + idx);
      if (wr) wr_data0(v);
      send_cmd(mk_cmd(8'h00, wr, rn));
      check("R8", "busy after accept", 32'(busy), 32'd1);
      wait_idle();
      check("R8", "cmderr after success", 32'(cmderr), 32'd0);
      if (cls == 0) check("R3", "csr_addr", 32'(last_csr_addr), 32'(rn[11:0]));
      if (wr) begin
         exp = v;
         if (cls == 0)      check("R3", "csr written", csr_mem[idx], exp);
         else if (cls == 1) check("R6", "scalar written", sc_mem[idx], exp);
         else               check("R7", "float written", fp_mem[idx], exp);
      end else begin
         exp = (cls == 0) ? csr_mem[idx] : (cls == 1) ? sc_mem[idx] : fp_mem[idx];
         if (cls == 0)      check("R4", "csr read", data0, exp);
         else if (cls == 1) check("R5", "scalar read", data0, exp);
         else               check("R7", "float read", data0, exp);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int c0, s0, f0;
      logic [31:0] d0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12", "busy", 32'(busy), 32'd0);
      check("R12", "cmderr", 32'(cmderr), 32'd0);
      check("R12", "data0", data0, 32'd0);
      check("R12", "strobes", 32'({csr_valid, sc_wr_valid, fp_wr_valid}), 32'd0);

      // R11 data0 write while idle
      wr_data0(32'hA5A5_0001);
      check("R11", "data0 idle write", data0, 32'hA5A5_0001);

      // R5 a0 read
      send_cmd(mk_cmd(8'h00, 1'b0, 16'h100A));
      check("R8", "busy after accept", 32'(busy), 32'd1);
      wait_idle();
      check("R5", "a0 read", data0, seed_val(1, 10));

      // R6 stalled scalar write, R11 data0 write ignored while busy
      ready_mode = 1;
      wr_data0(32'h1357_9BDF);
      send_cmd(mk_cmd(8'h00, 1'b1, 16'h1007));
      for (int k = 0; k < 4; k++) begin
         check("R6", "valid held", 32'(sc_wr_valid), 32'd1);
         check("R6", "idx held", 32'(sc_wr_idx), 32'd7);
         @(negedge clk);
      end
      wr_data0(32'hDEAD_BEEF);
      check("R11", "data0 unchanged while busy", data0, 32'h1357_9BDF);
      ready_mode = 2;
      wait_idle();
      check("R6", "scalar mem", sc_mem[7], 32'h1357_9BDF);
      check("R11", "data0 after", data0, 32'h1357_9BDF);
      ready_mode = 0;

      // R7 float boundaries, R5 scalar low edge, R3 csr top edge
      run_access(2, 31, 1'b0, '0);
      run_access(1, 0, 1'b0, '0);
      send_cmd(mk_cmd(8'h00, 1'b0, 16'h0FFF));
      wait_idle();
      check("R4", "csr 0xFFF read", data0, csr_mem[15]);
      check("R3", "csr 0xFFF addr", 32'(last_csr_addr), 32'hFFF);
      run_access(2, 3, 1'b1, 32'h0BAD_F00D);
      run_access(0, 2, 1'b1, 32'h00C0_FFEE);

      // R1 unsupported type, no access
      d0 = data0; c0 = n_csr; s0 = n_scw; f0 = n_fpw;
      send_cmd(mk_cmd(8'h02, 1'b1, 16'h1001));
      check("R1", "busy", 32'(busy), 32'd0);
      check("R1", "cmderr", 32'(cmderr), 32'd2);
      // R10 command ignored while error set
      send_cmd(mk_cmd(8'h00, 1'b1, 16'h0001));
      check("R10", "ignored busy", 32'(busy), 32'd0);
      check("R10", "cmderr held", 32'(cmderr), 32'd2);
      repeat (3) @(negedge clk);
      check("R1", "no strobes", 32'(n_csr + n_scw + n_fpw), 32'(c0 + s0 + f0));
      check("R1", "data0 kept", data0, d0);
      clear_err();
      check("R10", "cleared", 32'(cmderr), 32'd0);

      // R1 type check precedes range; R10 set wins over clear
      @(negedge clk); cmd_we = 1'b1; err_clr = 1'b1; cmd_wdata = mk_cmd(8'h01, 1'b0, 16'hFFFF);
      @(negedge clk); cmd_we = 1'b0; err_clr = 1'b0;
      check("R10", "set wins over clear", 32'(cmderr), 32'd2);
      clear_err();

      // R2 out of range
      send_cmd(mk_cmd(8'h00, 1'b0, 16'h1040));
      check("R2", "cmderr 0x1040", 32'(cmderr), 32'd3);
      check("R2", "busy", 32'(busy), 32'd0);
      clear_err();
      send_cmd(mk_cmd(8'h00, 1'b1, 16'hFFFF));
      check("R2", "cmderr 0xFFFF", 32'(cmderr), 32'd3);
      clear_err();

      // R9 command while busy on slow csr read
      csr_lat = 8;
      c0 = n_csr;
      send_cmd(mk_cmd(8'h00, 1'b0, 16'h0305));
      send_cmd(mk_cmd(8'h00, 1'b1, 16'h1002));
      check("R9", "cmderr busy", 32'(cmderr), 32'd1);
      wait_idle();
      check("R9", "access continued", data0, csr_mem[5]);
      check("R9", "one csr strobe", 32'(n_csr), 32'(c0 + 1));
      clear_err();
      csr_lat = 1;

      // R9 command in the completion cycle of a scalar read
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = mk_cmd(8'h00, 1'b0, 16'h100A);
      @(negedge clk); cmd_wdata = mk_cmd(8'h00, 1'b0, 16'h1003);
      @(negedge clk); cmd_we = 1'b0;
      check("R9", "collision cmderr", 32'(cmderr), 32'd1);
      check("R9", "collision data0", data0, sc_mem[10]);
      check("R9", "collision busy", 32'(busy), 32'd0);
      clear_err();

      // random mix
      for (int n = 0; n < 200; n++) begin
         int cls;
         cls = $urandom_range(0, 2);
         csr_lat = $urandom_range(0, 3);
         run_access(cls, (cls == 0) ? $urandom_range(0, 15) : $urandom_range(0, 31),
                    1'($urandom_range(0, 1)), $urandom);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule